// File: doc/BRIEF.md
# Compare-Match Timer with Single-Shot Halt

This block is a peripheral timer built around a free-running up-counter and one compare register. Software loads a compare value, typically the present count plus the desired delay, and then sets a run bit together with a mode bit. The counter advances on every clock edge where the tick enable is high and the timer is running. On each such tick the present count is compared with the compare register.

When the count equals the compare value on a tick, the block sets a sticky interrupt flag and raises a one-cycle event output. The mode bit selects what happens next. In continuous mode the timer keeps counting, and software must load a new compare value for the next event. In single-shot mode the timer drops its own run bit and halts, and software can read the run bit back to see that it has stopped.

A small register interface gives software four word addresses: control, compare, count (read and load) and status, where the flag is cleared by writing 1. The run bit is held by a two-state machine. Its states are HALT and RUN. Its transitions are START (control write with run=1 from HALT), STOP (control write with run=0 from RUN), AUTO_HALT (single-shot match from RUN) and the self-loops.

Top module: `ost_timer`

## Requirements
- R1: After reset the count, compare value, run bit (control bit 0), mode bit (control bit 1), flag (status bit 0) and event output are all zero.
- R2: On a clock edge with run=1 and tick_en=1, the count becomes count+1. It does not advance on an edge where tick_en is 0.
- R3: The count wraps from all ones to zero and keeps counting. A compare value just past the wrap matches after it.
- R4: A match is a tick edge with run=1 and count equal to compare. It sets the flag and drives match_out high for exactly the following cycle. The count still advances on that edge.
- R5: With mode=1 (single-shot), a match clears the run bit with no software write. The count then reads compare+1.
- R6: With mode=0 (continuous), the run bit stays set after a match and counting continues. No further match occurs until the count equals the compare value again.
- R7: Writing status (address 3) with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 has no effect. A match on the same edge as a clear leaves the flag set.
- R8: A control write (address 0) on the same edge as a single-shot match wins. The run and mode bits take the written values.
- R9: A write to the count (address 2) loads the count, even while running, and overrides the increment on that edge. This shifts the next match accordingly. Address 1 loads the compare value.
- R10: While run=0 the count holds its value. When restarted, counting resumes from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counting tick qualifier |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare, 2 count, 3 status |
| wr_data | input | W (16) | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | W (16) | Combinational read data |
| irq | output | 1 | Sticky match flag |
| match_out | output | 1 | One-cycle pulse after each match |

## Verification
Two pairs of events can land on the same edge. The first pair is a match and a write-1 flag clear. The second pair is a single-shot auto-halt and a software control write. Directed cases load count and compare so that the match edge is known exactly, then issue the clear or control write on that same edge. The flag must stay set, and the run bit must equal the written value. Random traffic also creates such collisions, and a cycle-level model in the bench judges every one of them through all four read addresses.

// File: rtl/ost_pkg.sv
package ost_pkg;
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int BIT_RUN  = 0;
    localparam int BIT_MODE = 1;
    localparam int BIT_FLAG = 0;
endpackage

// File: rtl/ost_ctrl_fsm.sv
module ost_ctrl_fsm
    import ost_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_run,
    input  logic wr_mode,
    input  logic hit,
    output logic running,
    output logic single
);
    run_state_t state_q, state_d;
    logic       mode_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // mode register: written only by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (ctrl_wr) mode_q <= wr_mode;
    end

    // next state: software write outranks the automatic halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl_wr && wr_run) state_d = ST_RUN;     // START
            end
            ST_RUN: begin
                if (ctrl_wr)           state_d = wr_run ? ST_RUN : ST_HALT; // STOP
                else if (hit && mode_q) state_d = ST_HALT;   // AUTO_HALT
            end
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        running = (state_q == ST_RUN);
        single  = mode_q;
    end
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         load,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] compare,
    output logic         hit
);
    logic [W-1:0] count_q, cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (load)    count_q <= wdata;
        else if (advance) count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= wdata;
    end

    always_comb begin
        count   = count_q;
        compare = cmp_q;
        hit     = advance && (count_q == cmp_q);
    end
endmodule

// File: rtl/ost_event.sv
module ost_event (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    output logic flag,
    output logic pulse
);
    logic flag_q, pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit)          flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
        end
    end

    assign flag  = flag_q;
    assign pulse = pulse_q;
endmodule

// File: rtl/ost_timer.sv
module ost_timer
    import ost_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              irq,
    output logic              match_out
);
    logic ctrl_wr, cmp_wr, cnt_wr, clr_req;
    logic running, single, hit, advance;
    logic [W-1:0] count, compare;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        cmp_wr  = wr_en && (wr_addr == A_CMP);
        cnt_wr  = wr_en && (wr_addr == A_CNT);
        clr_req = wr_en && (wr_addr == A_STAT) && wr_data[BIT_FLAG];
        advance = running && tick_en;
    end

    ost_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wr_run  (wr_data[BIT_RUN]),
        .wr_mode (wr_data[BIT_MODE]),
        .hit     (hit),
        .running (running),
        .single  (single)
    );

    ost_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .load    (cnt_wr),
        .cmp_wr  (cmp_wr),
        .wdata   (wr_data),
        .count   (count),
        .compare (compare),
        .hit     (hit)
    );

    ost_event u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .flag    (irq),
        .pulse   (match_out)
    );

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = {{(W-2){1'b0}}, single, running};
            A_CMP:   rd_data = compare;
            A_CNT:   rd_data = count;
            A_STAT:  rd_data = {{(W-1){1'b0}}, irq};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ost_timer_chk.sv
module ost_timer_chk
    import ost_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic              run,
    input logic              mode,
    input logic [W-1:0]      count,
    input logic [W-1:0]      compare,
    input logic              flag,
    input logic              pulse
);
    logic is_hit, w_ctrl, w_cnt, w_clr;
    assign is_hit = run && tick_en && (count == compare);
    assign w_ctrl = wr_en && (wr_addr == A_CTRL);
    assign w_cnt  = wr_en && (wr_addr == A_CNT);
    assign w_clr  = wr_en && (wr_addr == A_STAT) && wr_data[0];

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick_en && !w_cnt |=> count == W'($past(count) + 1'b1)); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !w_cnt |=> $stable(count)); // R10
    AST_MATCH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        is_hit |=> flag && pulse); // R4
    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(is_hit)); // R4
    AST_SINGLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        is_hit && mode && !w_ctrl |=> !run); // R5
    AST_CONT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        is_hit && !mode && !w_ctrl |=> run); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr && !is_hit |=> !flag); // R7
    AST_CTRL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        w_ctrl |=> run == $past(wr_data[0]) && mode == $past(wr_data[1])); // R8
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        w_cnt |=> count == $past(wr_data)); // R9
endmodule

bind ost_timer ost_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run     (running),
    .mode    (single),
    .count   (count),
    .compare (compare),
    .flag    (irq),
    .pulse   (match_out)
);

// File: tb/sim_ost_timer.sv
module sim_ost_timer;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq, match_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [W-1:0] m_cnt = '0, m_cmp = '0;
    logic m_run = 0, m_mode = 0, m_flag = 0, m_pulse = 0;

    always #2 clk = ~clk;

    ost_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .match_out(match_out)
    );

    function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {{(W-2){1'b0}}, m_mode, m_run};
            2'd1:    return m_cmp;
            2'd2:    return m_cnt;
            default: return {{(W-1){1'b0}}, m_flag};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic tk, input logic we, input logic [1:0] a,
                         input logic [W-1:0] d, input string tag);
        logic adv, hit;
        logic [W-1:0] n_cnt, n_cmp;
        logic n_run, n_mode, n_flag;
        @(negedge clk);
        tick_en = tk; wr_en = we; wr_addr = a; wr_data = d;
        adv   = m_run && tk;
        hit   = adv && (m_cnt == m_cmp);
        n_cnt = (we && a == 2'd2) ? d : (adv ? m_cnt + 1'b1 : m_cnt);
        n_cmp = (we && a == 2'd1) ? d : m_cmp;
        if (we && a == 2'd0) begin
            n_run = d[0]; n_mode = d[1];
        end else begin
            n_run = (hit && m_mode) ? 1'b0 : m_run; n_mode = m_mode;
        end
        n_flag = hit ? 1'b1 : ((we && a == 2'd3 && d[0]) ? 1'b0 : m_flag);
        @(posedge clk);
        m_cnt = n_cnt; m_cmp = n_cmp; m_run = n_run; m_mode = n_mode;
        m_flag = n_flag; m_pulse = hit;
        #1;
        for (int i = 0; i < 4; i++) begin
            rd_addr = 2'(i);
            #0.2;
            chk(tag, rd_data, exp_rd(2'(i)));
        end
        chk(tag, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_flag});
        chk(tag, {{(W-1){1'b0}}, match_out}, {{(W-1){1'b0}}, m_pulse});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R2: watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        cycle(0, 0, 2'd0, '0, "R1");
        // R10 stopped: ticks do nothing
        repeat (3) cycle(1, 0, 2'd0, '0, "R10");
        // R9 load, R4 match, R6 continuous
        cycle(0, 1, 2'd2, 16'd100, "R9");
        cycle(0, 1, 2'd1, 16'd103, "R9");
        cycle(0, 1, 2'd0, 16'd1, "R2");
        repeat (3) cycle(1, 0, 2'd0, '0, "R4");
        cycle(1, 0, 2'd0, '0, "R4");
        repeat (4) cycle(1, 0, 2'd0, '0, "R6");
        // R7 clear with bit0=0 has no effect, then bit0=1 clears
        cycle(0, 1, 2'd3, 16'hFFFE, "R7");
        cycle(0, 1, 2'd3, 16'd1, "R7");
        // R5 single-shot halt
        cycle(0, 1, 2'd0, 16'd0, "R5");
        cycle(0, 1, 2'd2, 16'd10, "R5");
        cycle(0, 1, 2'd1, 16'd12, "R5");
        cycle(0, 1, 2'd0, 16'd3, "R5");
        repeat (5) cycle(1, 0, 2'd0, '0, "R5");
        // R10 resume from held value
        cycle(0, 1, 2'd0, 16'd1, "R10");
        repeat (3) cycle(1, 0, 2'd0, '0, "R10");
        // R8 control write on the auto-halt edge wins
        cycle(0, 1, 2'd0, 16'd0, "R8");
        cycle(0, 1, 2'd2, 16'd20, "R8");
        cycle(0, 1, 2'd1, 16'd20, "R8");
        cycle(0, 1, 2'd0, 16'd3, "R8");
        cycle(1, 1, 2'd0, 16'd3, "R8");
        cycle(1, 0, 2'd0, '0, "R8");
        // R7 match on the clearing edge keeps the flag
        cycle(0, 1, 2'd0, 16'd0, "R7");
        cycle(0, 1, 2'd2, 16'd30, "R7");
        cycle(0, 1, 2'd1, 16'd30, "R7");
        cycle(0, 1, 2'd0, 16'd1, "R7");
        cycle(1, 1, 2'd3, 16'd1, "R7");
        cycle(0, 1, 2'd3, 16'd1, "R7");
        // R3 wrap-around
        cycle(0, 1, 2'd2, 16'hFFFE, "R3");
        cycle(0, 1, 2'd1, 16'd1, "R3");
        repeat (5) cycle(1, 0, 2'd0, '0, "R3");
        // R9 load while running shifts the match
        cycle(0, 1, 2'd1, 16'd50, "R9");
        cycle(1, 1, 2'd2, 16'd47, "R9");
        repeat (4) cycle(1, 0, 2'd0, '0, "R9");
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic tk, we;
            logic [1:0] a;
            logic [W-1:0] d;
            tk = ($urandom % 4) != 0;
            we = ($urandom % 6) == 0;
            a  = 2'($urandom % 4);
            case (a)
                2'd0:    d = W'($urandom % 4);
                2'd1:    d = m_cnt + W'($urandom % 10);
                2'd2:    d = ($urandom % 8 == 0) ? '1 : W'($urandom);
                default: d = W'($urandom % 2);
            endcase
            if (!m_run && ($urandom % 3 == 0)) begin
                we = 1'b1; a = 2'd0; d = W'(1 + 2 * ($urandom % 2));
            end
            cycle(tk, we, a, d, "R2");
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule